// File: doc/BRIEF.md
# Addressable RGB LED Chain Driver

This block drives the single serial data wire of a chain of addressable RGB LEDs. It holds one 24-bit colour word per LED in a small register array that is loaded with parameter values at reset. It sends the words in LED order, most significant bit first. Each bit is sent as a high pulse followed by a low pulse, and the lengths of both pulses depend on the bit value. After the final bit of the final LED, the line stays low long enough for the LEDs to latch their colours. The block then starts again from the first LED and keeps refreshing the chain without a break.

All pulse lengths are clock-cycle counts worked out at elaboration from the clock frequency parameter and a selected timing profile. Profile 0 is for the older LED revision and profile 1 is for the newer one. A single down-counter times every phase. The latch interval is not a separate state: it is added onto the low phase of the last bit. Elaboration stops if any derived count is below one cycle.

Top module: `ledchain_drv`

## Requirements
- R1: While reset is asserted the output is low. After reset is released, the output stays low for RST_C cycles, counted from the first clock edge that samples reset low, before the first rising edge.
- R2: Words go out in LED order 0, 1, …, NUM_LEDS−1, and each word is sent bit 23 first and bit 0 last. Word i is taken from bits [24·i+23 : 24·i] of INIT_WORDS.
- R3: A 0 bit is a high phase of exactly T0H_C cycles followed by a low phase of exactly T0L_C cycles.
- R4: A 1 bit is a high phase of exactly T1H_C cycles followed by a low phase of exactly T1L_C cycles.
- R5: Every count is round(nominal_ns × CLK_HZ / 10⁹). With PROFILE = 0 the nominal times are T0H 350, T0L 800, T1H 700, T1L 600 and latch 50000 ns. With PROFILE = 1 they are T0H 400, T0L 850, T1H 800, T1L 450 and latch 280000 ns.
- R6: The low phase of bit 0 of the last LED is longer than its normal low phase by exactly RST_C cycles.
- R7: After that lengthened low phase, the next high phase is bit 23 of LED 0. No other gap is added, so the chain repeats without end.
- R8: A synchronous reset in the middle of a frame drives the output low on the next clock edge. After release, the block repeats the R1 wait and restarts from bit 23 of LED 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_i | input | 1 | Synchronous active-high reset |
| led_o | output | 1 | Registered serial data line to the LED chain |

## Verification
A corrupted down-counter shows up at the output straight away as a pulse that is too long or too short, within the phase in which the error happens. A bit or LED index that skips or repeats a position does not change any pulse width. It only shows as a high or low width that belongs to a different bit value, or as the latch-length low phase arriving at the wrong place, so it can take up to a whole frame to appear. The scoreboard therefore checks the exact width of every phase over two complete frames and the restart after them. A second instance with the newer profile checks the derived counts and the lengthened final low phase.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

   localparam int WORD_BITS = 24;

   typedef enum logic [1:0] {
      ST_RESET = 2'd0,
      ST_HIGH  = 2'd1,
      ST_LOW   = 2'd2
   } seq_state_t;

   // phase selector for nominal_ns
   localparam int PH_ZERO_HI = 0;
   localparam int PH_ZERO_LO = 1;
   localparam int PH_ONE_HI  = 2;
   localparam int PH_ONE_LO  = 3;
   localparam int PH_LATCH   = 4;

   function automatic int nominal_ns(input int profile, input int phase);
      int t;
      if (profile == 0) begin
         case (phase)
            PH_ZERO_HI: t = 350;
            PH_ZERO_LO: t = 800;
            PH_ONE_HI:  t = 700;
            PH_ONE_LO:  t = 600;
            default:    t = 50000;
         endcase
      end else begin
         case (phase)
            PH_ZERO_HI: t = 400;
            PH_ZERO_LO: t = 850;
            PH_ONE_HI:  t = 800;
            PH_ONE_LO:  t = 450;
            default:    t = 280000;
         endcase
      end
      return t;
   endfunction

   // rounded product of a time in ns and a frequency in Hz
   function automatic int ns_to_cycles(input int ns, input longint hz);
      longint prod;
      prod = longint'(ns) * hz + 64'sd500_000_000;
      return int'(prod / 64'sd1_000_000_000);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ledchain_store.sv
module ledchain_store #(
   parameter int NUM_LEDS = 4,
   parameter int LIW      = 2,
   parameter logic [NUM_LEDS*24-1:0] INIT_WORDS = '0
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic [LIW-1:0] rd_led_i,
   input  logic [4:0]     rd_bit_i,
   output logic           bit_o
);

   logic [23:0] words [NUM_LEDS];

   for (genvar i = 0; i < NUM_LEDS; i++) begin : g_word
      always_ff @(posedge clk_i) begin
         if (rst_i) words[i] <= INIT_WORDS[i*24 +: 24];
      end
   end

   if (NUM_LEDS == 1) begin : g_single
      assign bit_o = words[0][rd_bit_i];
   end else begin : g_multi
      assign bit_o = words[rd_led_i][rd_bit_i];
   end

endmodule

// File: rtl/ledchain_phase.sv
module ledchain_phase #(
   parameter int CW    = 12,
   parameter int T0H_C = 4,
   parameter int T0L_C = 8,
   parameter int T1H_C = 7,
   parameter int T1L_C = 6,
   parameter int RST_C = 500
) (
   input  logic          bit_i,
   input  logic          last_i,
   output logic [CW-1:0] high_len_o,
   output logic [CW-1:0] low_len_o
);

   localparam logic [CW-1:0] H0 = CW'(T0H_C);
   localparam logic [CW-1:0] L0 = CW'(T0L_C);
   localparam logic [CW-1:0] H1 = CW'(T1H_C);
   localparam logic [CW-1:0] L1 = CW'(T1L_C);
   localparam logic [CW-1:0] LT = CW'(RST_C);

   always_comb begin
      high_len_o = bit_i ? H1 : H0;
      low_len_o  = (bit_i ? L1 : L0) + (last_i ? LT : '0);
   end

endmodule

// File: rtl/ledchain_seq.sv
module ledchain_seq
   import ledchain_pkg::*;
#(
   parameter int NUM_LEDS = 4,
   parameter int LIW      = 2,
   parameter int CW       = 12,
   parameter int RST_C    = 500
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic [CW-1:0]  high_len_i,
   input  logic [CW-1:0]  low_len_i,
   output logic [LIW-1:0] rd_led_o,
   output logic [4:0]     rd_bit_o,
   output logic           last_o,
   output logic           led_o
);

   localparam logic [LIW-1:0] LAST_LED = LIW'(NUM_LEDS - 1);
   localparam logic [4:0]     TOP_BIT  = 5'(WORD_BITS - 1);

   seq_state_t     st;
   logic [CW-1:0]  cnt;
   logic [LIW-1:0] led_idx, nxt_led;
   logic [4:0]     bit_idx, nxt_bit;
   logic           last_led;

   always_comb begin
      last_led = (led_idx == LAST_LED);
      if (bit_idx == '0) begin
         nxt_bit = TOP_BIT;
         nxt_led = last_led ? '0 : led_idx + LIW'(1);
      end else begin
         nxt_bit = bit_idx - 5'd1;
         nxt_led = led_idx;
      end
      // while low, look up the bit that follows
      rd_led_o = (st == ST_LOW) ? nxt_led : led_idx;
      rd_bit_o = (st == ST_LOW) ? nxt_bit : bit_idx;
      last_o   = last_led && (bit_idx == '0);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st      <= ST_RESET;
         cnt     <= CW'(RST_C - 1);
         led_idx <= '0;
         bit_idx <= TOP_BIT;
         led_o   <= 1'b0;
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end else begin
         case (st)
            ST_RESET: begin
               st    <= ST_HIGH;
               cnt   <= high_len_i - CW'(1);
               led_o <= 1'b1;
            end
            ST_HIGH: begin
               st    <= ST_LOW;
               cnt   <= low_len_i - CW'(1);
               led_o <= 1'b0;
            end
            ST_LOW: begin
               st      <= ST_HIGH;
               led_idx <= nxt_led;
               bit_idx <= nxt_bit;
               cnt     <= high_len_i - CW'(1);
               led_o   <= 1'b1;
            end
            default: st <= ST_RESET;
         endcase
      end
   end

   assert_idx_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (led_idx <= LAST_LED) && (bit_idx <= TOP_BIT));

   assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == ST_RESET) |-> !led_o);

   assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt != '0) |=> $stable(led_o));

   assert_rise_in_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(led_o) |-> (st == ST_HIGH));

   assert_last_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == ST_HIGH && cnt == '0 && last_o) |=> (cnt >= CW'(RST_C)));

   assert_wrap_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == ST_LOW && cnt == '0 && last_o) |=> (led_idx == '0 && bit_idx == TOP_BIT));

endmodule

// File: rtl/ledchain_drv.sv
module ledchain_drv
   import ledchain_pkg::*;
#(
   parameter int     NUM_LEDS = 4,
   parameter longint CLK_HZ   = 20_000_000,
   parameter int     PROFILE  = 1,
   parameter logic [NUM_LEDS*24-1:0] INIT_WORDS = {NUM_LEDS{24'h30_10_08}}
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic led_o
);

   localparam int T0H_C = ns_to_cycles(nominal_ns(PROFILE, PH_ZERO_HI), CLK_HZ);
   localparam int T0L_C = ns_to_cycles(nominal_ns(PROFILE, PH_ZERO_LO), CLK_HZ);
   localparam int T1H_C = ns_to_cycles(nominal_ns(PROFILE, PH_ONE_HI), CLK_HZ);
   localparam int T1L_C = ns_to_cycles(nominal_ns(PROFILE, PH_ONE_LO), CLK_HZ);
   localparam int RST_C = ns_to_cycles(nominal_ns(PROFILE, PH_LATCH), CLK_HZ);
   localparam int MAX_LEN = max2(max2(T0H_C, T1H_C), max2(T0L_C, T1L_C) + RST_C);
   localparam int CW  = $clog2(MAX_LEN + 1);
   localparam int LIW = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;

   if (NUM_LEDS < 1) begin : g_bad_count
      $fatal(1, "ledchain_drv: NUM_LEDS must be at least 1");
   end
   if (PROFILE != 0 && PROFILE != 1) begin : g_bad_profile
      $fatal(1, "ledchain_drv: PROFILE must be 0 or 1");
   end
   if (T0H_C < 1 || T0L_C < 1 || T1H_C < 1 || T1L_C < 1 || RST_C < 1) begin : g_bad_clk
      $fatal(1, "ledchain_drv: CLK_HZ too low, a phase rounds to zero cycles");
   end

   logic [LIW-1:0] rd_led;
   logic [4:0]     rd_bit;
   logic           cur_bit, last_bit;
   logic [CW-1:0]  high_len, low_len;

   ledchain_store #(
      .NUM_LEDS  (NUM_LEDS),
      .LIW       (LIW),
      .INIT_WORDS(INIT_WORDS)
   ) u_store (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .rd_led_i(rd_led),
      .rd_bit_i(rd_bit),
      .bit_o   (cur_bit)
   );

   ledchain_phase #(
      .CW   (CW),
      .T0H_C(T0H_C),
      .T0L_C(T0L_C),
      .T1H_C(T1H_C),
      .T1L_C(T1L_C),
      .RST_C(RST_C)
   ) u_phase (
      .bit_i     (cur_bit),
      .last_i    (last_bit),
      .high_len_o(high_len),
      .low_len_o (low_len)
   );

   ledchain_seq #(
      .NUM_LEDS(NUM_LEDS),
      .LIW     (LIW),
      .CW      (CW),
      .RST_C   (RST_C)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .high_len_i(high_len),
      .low_len_i (low_len),
      .rd_led_o  (rd_led),
      .rd_bit_o  (rd_bit),
      .last_o    (last_bit),
      .led_o     (led_o)
   );

endmodule

// File: tb/ledchain_drv_bench.sv
module ledchain_drv_bench;

   // instance A: older profile at 10 MHz -> 4/8/7/6 and 500 cycles
   localparam int A_T0H = 4, A_T0L = 8, A_T1H = 7, A_T1L = 6, A_RST = 500;
   // instance B: newer profile at 10 MHz -> 4/9/8/5 and 2800 cycles
   localparam int B_T0H = 4, B_T0L = 9, B_T1H = 8, B_T1L = 5, B_RST = 2800;

   localparam logic [23:0] W0 = 24'hF0_0F_A5;
   localparam logic [23:0] W1 = 24'h00_00_01;
   localparam logic [23:0] W2 = 24'h80_FF_00;
   localparam logic [23:0] WB = 24'h80_00_01;

   logic clk = 1'b0;
   logic rst_a = 1'b1;
   logic rst_b = 1'b1;
   logic led_a, led_b;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   b_done  = 1'b0;

   int    exp_hi_q[$];
   int    exp_lo_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   ledchain_drv #(
      .NUM_LEDS  (3),
      .CLK_HZ    (10_000_000),
      .PROFILE   (0),
      .INIT_WORDS({W2, W1, W0})
   ) u_ledchain_drv (
      .clk_i(clk),
      .rst_i(rst_a),
      .led_o(led_a)
   );

   ledchain_drv #(
      .NUM_LEDS  (1),
      .CLK_HZ    (10_000_000),
      .PROFILE   (1),
      .INIT_WORDS(WB)
   ) u_ledchain_drv_b (
      .clk_i(clk),
      .rst_i(rst_b),
      .led_o(led_b)
   );

   task automatic check(input int act, input int exp, input string req, input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: push expected pulse widths for one whole frame of instance A
   task automatic push_frame(input string first_tag);
      logic [23:0] w [3];
      int hi, lo;
      string tg;
      w[0] = W0; w[1] = W1; w[2] = W2;
      for (int l = 0; l < 3; l++) begin
         for (int b = 23; b >= 0; b--) begin
            hi = w[l][b] ? A_T1H : A_T0H;
            lo = w[l][b] ? A_T1L : A_T0L;
            tg = w[l][b] ? "R4" : "R3";
            if (l == 2 && b == 0) begin
               lo = lo + A_RST;
               tg = "R6";
            end
            if (l == 0 && b == 23) tg = first_tag;
            exp_hi_q.push_back(hi);
            exp_lo_q.push_back(lo);
            tag_q.push_back(tg);
         end
      end
   endtask

   // call when the current negedge sample of the line is high
   task automatic measure_a(output int hi, output int lo);
      hi = 0;
      while (led_a === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (led_a === 1'b0) begin lo++; @(negedge clk); end
   endtask

   task automatic measure_b(output int hi, output int lo);
      hi = 0;
      while (led_b === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (led_b === 1'b0) begin lo++; @(negedge clk); end
   endtask

   // idle low width: samples after release = cycles - 1 (rise on edge RST_C)
   task automatic idle_a(output int n);
      n = 0;
      @(negedge clk);
      while (led_a === 1'b0 && n < 10000) begin n++; @(negedge clk); end
   endtask

   // main flow, instance A
   initial begin
      int n, hi, lo, eh, el;
      string tg;
      repeat (3) @(negedge clk);
      check(int'(led_a), 0, "R1", "output low during reset");
      rst_a = 1'b0;
      idle_a(n);
      check(n, A_RST - 1, "R1", "initial low before first bit");

      // scoreboard: two frames, second frame's first bit is the wrap (R2, R7)
      push_frame("R2");
      push_frame("R7");
      while (exp_hi_q.size() > 0) begin
         measure_a(hi, lo);
         eh = exp_hi_q.pop_front();
         el = exp_lo_q.pop_front();
         tg = tag_q.pop_front();
         check(hi, eh, tg, "high width");
         check(lo, el, tg, "low width");
      end

      // R8: reset in the middle of a high pulse
      repeat (2) @(negedge clk);
      check(int'(led_a), 1, "R8", "mid-pulse before reset");
      rst_a = 1'b1;
      @(negedge clk);
      check(int'(led_a), 0, "R8", "output low one edge after reset");
      repeat (2) @(negedge clk);
      rst_a = 1'b0;
      idle_a(n);
      check(n, A_RST - 1, "R8", "low wait repeated after reset");
      measure_a(hi, lo);
      check(hi, A_T1H, "R8", "restart at bit 23 of LED 0 high");
      check(lo, A_T1L, "R8", "restart at bit 23 of LED 0 low");

      wait (b_done);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // instance B: newer profile derived counts and lengthened final low
   initial begin
      int n, hi, lo;
      repeat (3) @(negedge clk);
      rst_b = 1'b0;
      n = 0;
      @(negedge clk);
      while (led_b === 1'b0 && n < 10000) begin n++; @(negedge clk); end
      check(n, B_RST - 1, "R5", "newer profile latch count");
      for (int p = 23; p >= 0; p--) begin
         measure_b(hi, lo);
         if (p == 23) begin
            check(hi, B_T1H, "R5", "newer T1H");
            check(lo, B_T1L, "R5", "newer T1L");
         end else if (p == 22) begin
            check(hi, B_T0H, "R5", "newer T0H");
            check(lo, B_T0L, "R5", "newer T0L");
         end else if (p == 0) begin
            check(hi, B_T1H, "R6", "single-LED last bit high");
            check(lo, B_T1L + B_RST, "R6", "single-LED last bit low");
         end
      end
      b_done = 1'b1;
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule